// File: doc/BRIEF.md
# Time and Calendar Counter

This block keeps time of day and a calendar in seven byte-wide fields: seconds, minutes, hours, day of week, date of month, month and two-digit year. A one-cycle pulse on the tick input advances the time by one second. The carry runs through minutes, hours, day of week, date, month and year. Month lengths and the leap-year rule for February are applied. A small register bus lets software read and write the time fields, three alarm bytes and one control byte. The control byte selects BCD or binary encoding and 12-hour or 24-hour hours. It also holds a freeze bit that stops the tick-driven advance while software loads a new time.

The fields are counted internally as plain binary, with hours always 0–23. The bus encodes each field on the way out and decodes it on the way in, using the control byte as it stands at that moment. A bus write to a time field first lands in a holding copy. The holding copy moves into the counting copy on the next cycle that carries no advance. The counting copy therefore changes in one step, and a read never sees a set of fields that is only partly updated.

Top module: `tod_calendar`

## Requirements
- R1: After reset the bus reads seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01 and year 00. The control byte reads 02h (24-hour form, BCD, not frozen).
- R2: Time fields are at these addresses: seconds 0h, minutes 2h, hours 4h, day of week 6h, date 7h, month 8h, year 9h. Alarm bytes at 1h, 3h and 5h, and the control byte at Bh, read back exactly as written. Any other address reads 00h, and a write to it changes nothing.
- R3: Each tick pulse (one cycle high on `tick_1hz`) adds one second. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. In 24-hour form, hours wrap 23→0.
- R4: Control bit 2 picks the encoding of every time field on read and on write: 0 means BCD, where 59 is 59h, and 1 means binary, where 59 is 3Bh.
- R5: Control bit 1 picks the hour form: 1 is 24-hour and 0 is 12-hour. In 12-hour form the hours byte holds 1–12 in bits 6:0, and bit 7 is set for PM. 11 AM is followed by 12 PM, and 12 AM by 1 AM. 11:59:59 PM rolls to 12:00:00 AM and advances the date.
- R6: Day of week counts 1 to 7, advances by one when the hours wrap at midnight, and follows 7 with 1.
- R7: When the date is past the last day of its month at midnight, it rolls to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of four, and 28 otherwise. Month 12 rolls to month 1, and the year advances, wrapping 99→00.
- R8: While control bit 7 is 1, tick pulses are dropped and the time does not change. They are not stored, so clearing the bit resumes counting from the frozen value.
- R9: Bit 7 of a write to the seconds field is ignored, and the seconds field always reads bit 7 as 0.
- R10: A time-field write reaches the read port after the next clock edge that carries no advance. If a tick advance falls in the same cycle as the write, the advanced time is readable first, and one cycle later the written value replaces that field.
- R11: Hours are held internally in a 24-hour count. A write is decoded with the hour form in force when it is written, and a read is encoded with the hour form in force when it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational from the counting copy) |

## Verification
The bench sweeps all 24 hours in 12-hour BCD form and checks the encoding after each tick. A design that mishandled the noon or midnight crossover would show 00 or 13 instead of 12, or would fail to advance the date. It also sweeps every month of a leap year, a common year and year 99, both at the last day and the day before it. A wrong month-length table or leap rule would roll a day too early or too late, and a missing year wrap would read 100. A write that coincides with a tick checks the holding-copy ordering: a design that lost the write, or let the tick overwrite it, would show the ticked value for good. Ticks sent while the freeze bit is set check that they are dropped rather than stored and replayed.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int VAL_W    = 7;
    localparam int NFIELD   = 7;
    localparam int NALARM   = 3;

    // Bus map: time fields and alarm bytes interleave, control apart
    localparam logic [ADDR_W-1:0] A_SEC   = 4'h0;
    localparam logic [ADDR_W-1:0] A_SECAL = 4'h1;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'h2;
    localparam logic [ADDR_W-1:0] A_MINAL = 4'h3;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'h4;
    localparam logic [ADDR_W-1:0] A_HRAL  = 4'h5;
    localparam logic [ADDR_W-1:0] A_DOW   = 4'h6;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'h7;
    localparam logic [ADDR_W-1:0] A_MON   = 4'h8;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'h9;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'hB;

    // Control byte bit positions
    localparam int CB_FREEZE = 7;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h02;

    typedef enum logic [2:0] {
        F_SEC, F_MIN, F_HOUR, F_DOW, F_DATE, F_MON, F_YEAR
    } field_e;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    localparam tod_t TOD_RESET = '{year: 7'd0, mon: 4'd1, date: 5'd1,
                                   dow: 3'd1, hour: 5'd0, min: 6'd0,
                                   sec: 6'd0};

    function automatic logic [DATA_W-1:0] to_bcd(input logic [VAL_W-1:0] v);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [VAL_W-1:0] from_bcd(input logic [DATA_W-1:0] b);
        logic [VAL_W-1:0] tens;
        tens = {4'b0, b[6:4]};
        return tens * 7'd10 + {3'b0, b[3:0]};
    endfunction

    function automatic logic [DATA_W-1:0] enc_val(input logic [VAL_W-1:0] v,
                                                  input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [VAL_W-1:0] dec_val(input logic [DATA_W-1:0] b,
                                                 input logic bin);
        return bin ? b[6:0] : from_bcd(b);
    endfunction

    function automatic logic [DATA_W-1:0] enc_hour(input logic [4:0] h,
                                                   input logic bin,
                                                   input logic h24);
        logic [VAL_W-1:0] v;
        logic [DATA_W-1:0] e;
        logic pm;
        if (h24) begin
            return enc_val({2'b0, h}, bin);
        end
        pm = (h >= 5'd12);
        v  = {2'b0, pm ? h - 5'd12 : h};
        if (v == 7'd0) v = 7'd12;
        e = enc_val(v, bin);
        return {pm, e[6:0]};
    endfunction

    function automatic logic [4:0] dec_hour(input logic [DATA_W-1:0] b,
                                            input logic bin,
                                            input logic h24);
        logic [VAL_W-1:0] v;
        v = dec_val({1'b0, b[6:0]}, bin);
        if (h24) return v[4:0];
        if (v == 7'd12) return b[7] ? 5'd12 : 5'd0;
        return b[7] ? v[4:0] + 5'd12 : v[4:0];
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon,
                                              input logic [6:0] year);
        case (mon)
            4'd2:                       return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

    function automatic tod_t set_field(input tod_t t, input field_e f,
                                       input logic [VAL_W-1:0] v);
        tod_t r;
        r = t;
        case (f)
            F_SEC:   r.sec  = v[5:0];
            F_MIN:   r.min  = v[5:0];
            F_HOUR:  r.hour = v[4:0];
            F_DOW:   r.dow  = v[2:0];
            F_DATE:  r.date = v[4:0];
            F_MON:   r.mon  = v[3:0];
            default: r.year = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tod_advance.sv
module tod_advance
    import tod_pkg::*;
(
    input  tod_t cur,
    output tod_t nxt
);
    logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap;

    always_comb begin
        sec_wrap  = (cur.sec  == 6'd59);
        min_wrap  = sec_wrap  && (cur.min  == 6'd59);
        hour_wrap = min_wrap  && (cur.hour == 5'd23);
        date_wrap = hour_wrap && (cur.date >= month_days(cur.mon, cur.year));
        mon_wrap  = date_wrap && (cur.mon  == 4'd12);

        nxt = cur;
        nxt.sec = sec_wrap ? 6'd0 : cur.sec + 6'd1;
        if (sec_wrap)
            nxt.min = min_wrap ? 6'd0 : cur.min + 6'd1;
        if (min_wrap)
            nxt.hour = hour_wrap ? 5'd0 : cur.hour + 5'd1;
        if (hour_wrap) begin
            nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            nxt.date = date_wrap ? 5'd1 : cur.date + 5'd1;
        end
        if (date_wrap)
            nxt.mon = mon_wrap ? 4'd1 : cur.mon + 4'd1;
        if (mon_wrap)
            nxt.year = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
    end
endmodule

// File: rtl/tod_wdecode.sv
module tod_wdecode
    import tod_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bin,
    input  logic              h24,
    output logic              time_we,
    output field_e            field,
    output logic [VAL_W-1:0]  val
);
    always_comb begin
        time_we = we;
        field   = F_SEC;
        val     = dec_val(wdata, bin);
        case (addr)
            A_SEC: begin
                field = F_SEC;
                val   = dec_val({1'b0, wdata[6:0]}, bin);
            end
            A_MIN:  field = F_MIN;
            A_HOUR: begin
                field = F_HOUR;
                val   = {2'b0, dec_hour(wdata, bin, h24)};
            end
            A_DOW:  field = F_DOW;
            A_DATE: field = F_DATE;
            A_MON:  field = F_MON;
            A_YEAR: field = F_YEAR;
            default: time_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/tod_shadow.sv
module tod_shadow
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic             advance,
    input  tod_t             nxt,
    input  logic             wr_en,
    input  field_e           wr_field,
    input  logic [VAL_W-1:0] wr_val,
    output tod_t             cnt
);
    tod_t              cnt_q;
    tod_t              merged;
    logic [NFIELD-1:0] pend_q;
    logic [NFIELD-1:0] wr_mask;
    logic [VAL_W-1:0]  hold_q [NFIELD];

    for (genvar g = 0; g < NFIELD; g++) begin : g_hold
        assign wr_mask[g] = wr_en && (wr_field == field_e'(g));
        always_ff @(posedge clk) begin
            if (rst)             hold_q[g] <= '0;
            else if (wr_mask[g]) hold_q[g] <= wr_val;
        end
    end

    always_comb begin
        merged = cnt_q;
        for (int i = 0; i < NFIELD; i++)
            if (pend_q[i]) merged = set_field(merged, field_e'(i), hold_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= TOD_RESET;
            pend_q <= '0;
        end else begin
            cnt_q  <= advance ? nxt : merged;
            pend_q <= (advance ? pend_q : '0) | wr_mask;
        end
    end

    assign cnt = cnt_q;

    // R3: a tick below the wrap point adds exactly one second
    a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q.sec != 6'd59) |=> cnt_q.sec == $past(cnt_q.sec) + 6'd1);

    // R3: time fields stay inside their ranges
    a_r3_time_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q.sec < 6'd60 && cnt_q.min < 6'd60 && cnt_q.hour < 5'd24);

    // R6: day of week stays 1..7 and moves at midnight
    a_r6_dow_midnight: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q.sec == 6'd59 && cnt_q.min == 6'd59 && cnt_q.hour == 5'd23)
        |=> cnt_q.dow != $past(cnt_q.dow) && cnt_q.dow >= 3'd1 && cnt_q.dow <= 3'd7);

    // R7: at midnight the date either steps by one or restarts at 1
    a_r7_date_step: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q.sec == 6'd59 && cnt_q.min == 6'd59 && cnt_q.hour == 5'd23)
        |=> (cnt_q.date == 5'd1 || cnt_q.date == $past(cnt_q.date) + 5'd1));

    // R8: frozen with nothing pending, the time holds
    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        (freeze && pend_q == '0) |=> $stable(cnt_q));

    // R10: an advance never discards a pending write
    a_r10_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (advance && pend_q != '0) |=> (pend_q & $past(pend_q)) == $past(pend_q));
endmodule

// File: rtl/tod_rmux.sv
module tod_rmux
    import tod_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  tod_t              cnt,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] al_sec,
    input  logic [DATA_W-1:0] al_min,
    input  logic [DATA_W-1:0] al_hour,
    output logic [DATA_W-1:0] rdata
);
    logic bin, h24;

    always_comb begin
        bin = ctrl[CB_BIN];
        h24 = ctrl[CB_H24];
        case (addr)
            A_SEC:   rdata = enc_val({1'b0, cnt.sec}, bin);
            A_SECAL: rdata = al_sec;
            A_MIN:   rdata = enc_val({1'b0, cnt.min}, bin);
            A_MINAL: rdata = al_min;
            A_HOUR:  rdata = enc_hour(cnt.hour, bin, h24);
            A_HRAL:  rdata = al_hour;
            A_DOW:   rdata = enc_val({4'b0, cnt.dow}, bin);
            A_DATE:  rdata = enc_val({2'b0, cnt.date}, bin);
            A_MON:   rdata = enc_val({3'b0, cnt.mon}, bin);
            A_YEAR:  rdata = enc_val(cnt.year, bin);
            A_CTRL:  rdata = ctrl;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] alarm_q [NALARM];
    logic              freeze, advance;
    logic              time_we;
    field_e            wr_field;
    logic [VAL_W-1:0]  wr_val;
    tod_t              cnt, nxt;

    assign freeze  = ctrl_q[CB_FREEZE];
    assign advance = tick_1hz && !freeze;

    always_ff @(posedge clk) begin
        if (rst)                                ctrl_q <= CTRL_RESET;
        else if (bus_we && bus_addr == A_CTRL)  ctrl_q <= bus_wdata;
    end

    for (genvar g = 0; g < NALARM; g++) begin : g_alarm
        localparam logic [ADDR_W-1:0] AL_ADDR = ADDR_W'(2 * g + 1);
        always_ff @(posedge clk) begin
            if (rst)                                alarm_q[g] <= '0;
            else if (bus_we && bus_addr == AL_ADDR) alarm_q[g] <= bus_wdata;
        end
    end

    tod_wdecode u_wdecode (
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .bin     (ctrl_q[CB_BIN]),
        .h24     (ctrl_q[CB_H24]),
        .time_we (time_we),
        .field   (wr_field),
        .val     (wr_val)
    );

    tod_advance u_advance (
        .cur (cnt),
        .nxt (nxt)
    );

    tod_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .freeze   (freeze),
        .advance  (advance),
        .nxt      (nxt),
        .wr_en    (time_we),
        .wr_field (wr_field),
        .wr_val   (wr_val),
        .cnt      (cnt)
    );

    tod_rmux u_rmux (
        .addr    (bus_addr),
        .cnt     (cnt),
        .ctrl    (ctrl_q),
        .al_sec  (alarm_q[0]),
        .al_min  (alarm_q[1]),
        .al_hour (alarm_q[2]),
        .rdata   (bus_rdata)
    );

    // R1: control byte comes out of reset at its defined value
    a_r1_ctrl_reset: assert property (@(posedge clk)
        $past(rst) |-> ctrl_q == CTRL_RESET);

    // R8: a tick while frozen produces no advance
    a_r8_no_advance: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !advance);
endmodule

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tod_calendar dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] h12(input int h);
        int v;
        v = h % 12;
        if (v == 0) v = 12;
        return {(h >= 12) ? 1'b1 : 1'b0, 7'(bcd(v))};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        @(posedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_chk("R1 sec",  4'h0, 8'h00);
        rd_chk("R1 min",  4'h2, 8'h00);
        rd_chk("R1 hour", 4'h4, 8'h00);
        rd_chk("R1 dow",  4'h6, 8'h01);
        rd_chk("R1 date", 4'h7, 8'h01);
        rd_chk("R1 mon",  4'h8, 8'h01);
        rd_chk("R1 year", 4'h9, 8'h00);
        rd_chk("R1 ctrl", 4'hB, 8'h02);

        // R2 alarm bytes raw, unmapped address inert
        wr(4'h1, 8'hC5); wr(4'h3, 8'hFF); wr(4'h5, 8'h92);
        wr(4'hC, 8'h77); wr(4'hA, 8'h33);
        rd_chk("R2 alarm sec",  4'h1, 8'hC5);
        rd_chk("R2 alarm min",  4'h3, 8'hFF);
        rd_chk("R2 alarm hour", 4'h5, 8'h92);
        rd_chk("R2 unmapped C", 4'hC, 8'h00);
        rd_chk("R2 unmapped A", 4'hA, 8'h00);
        rd_chk("R2 sec untouched", 4'h0, 8'h00);

        // R3 R4 BCD carry chain in 24-hour form
        wr(4'h0, 8'h58); wr(4'h2, 8'h59); wr(4'h4, 8'h09);
        tick();
        rd_chk("R3 sec 59", 4'h0, 8'h59);
        tick();
        rd_chk("R3 sec wrap", 4'h0, 8'h00);
        rd_chk("R3 min wrap", 4'h2, 8'h00);
        rd_chk("R4 bcd hour", 4'h4, 8'h10);

        // R4 binary mode
        wr(4'hB, 8'h06);
        rd_chk("R4 bin hour", 4'h4, 8'h0A);
        wr(4'h0, 8'h3A);
        tick();
        rd_chk("R4 bin sec 3B", 4'h0, 8'h3B);
        tick();
        rd_chk("R4 bin sec wrap", 4'h0, 8'h00);
        rd_chk("R4 bin min", 4'h2, 8'h01);

        // R9 seconds bit 7 read-only
        wr(4'hB, 8'h02);
        wr(4'h0, 8'hA5);
        rd_chk("R9 sec msb", 4'h0, 8'h25);

        // R5 12-hour sweep over all hours
        wr(4'hB, 8'h00);
        for (int h = 0; h < 24; h++) begin
            wr(4'h4, h12(h)); wr(4'h2, 8'h59); wr(4'h0, 8'h59); wr(4'h7, 8'h10);
            tick();
            rd_chk($sformatf("R5 hour after %0d", h), 4'h4, h12((h + 1) % 24));
            rd_chk($sformatf("R5 date after %0d", h), 4'h7, (h == 23) ? 8'h11 : 8'h10);
        end

        // R6 day of week at midnight
        wr(4'hB, 8'h02);
        for (int d = 1; d <= 7; d++) begin
            wr(4'h6, 8'(d)); wr(4'h7, 8'h05); wr(4'h8, 8'h03);
            wr(4'h4, 8'h23); wr(4'h2, 8'h59); wr(4'h0, 8'h59);
            tick();
            rd_chk($sformatf("R6 dow after %0d", d), 4'h6, 8'((d == 7) ? 1 : d + 1));
        end

        // R7 month lengths, leap rule, year wrap (binary 24-hour)
        wr(4'hB, 8'h06);
        for (int yi = 0; yi < 3; yi++) begin
            int y;
            y = (yi == 0) ? 0 : (yi == 1) ? 1 : 99;
            for (int m = 1; m <= 12; m++) begin
                for (int last = 0; last < 2; last++) begin
                    int dd;
                    dd = mdays(m, y) - 1 + last;
                    wr(4'h9, 8'(y)); wr(4'h8, 8'(m)); wr(4'h7, 8'(dd));
                    wr(4'h4, 8'd23); wr(4'h2, 8'd59); wr(4'h0, 8'd59);
                    tick();
                    if (last == 0) begin
                        rd_chk($sformatf("R7 y%0d m%0d eve date", y, m), 4'h7, 8'(dd + 1));
                        rd_chk($sformatf("R7 y%0d m%0d eve mon", y, m), 4'h8, 8'(m));
                    end else begin
                        rd_chk($sformatf("R7 y%0d m%0d roll date", y, m), 4'h7, 8'h01);
                        rd_chk($sformatf("R7 y%0d m%0d roll mon", y, m), 4'h8,
                               8'((m == 12) ? 1 : m + 1));
                        rd_chk($sformatf("R7 y%0d m%0d roll year", y, m), 4'h9,
                               8'((m == 12) ? (y + 1) % 100 : y));
                    end
                end
            end
        end

        // R8 freeze drops ticks
        wr(4'hB, 8'h82);
        wr(4'h0, 8'h20); wr(4'h2, 8'h10);
        for (int k = 0; k < 5; k++) tick();
        rd_chk("R8 frozen sec", 4'h0, 8'h20);
        rd_chk("R8 frozen min", 4'h2, 8'h10);
        wr(4'hB, 8'h02);
        tick();
        rd_chk("R8 resumed sec", 4'h0, 8'h21);

        // R10 write colliding with a tick
        @(negedge clk);
        bus_addr = 4'h0; bus_wdata = 8'h40; bus_we = 1'b1; tick_1hz = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; tick_1hz = 1'b0;
        #1;
        check("R10 ticked first", bus_rdata, 8'h22);
        @(posedge clk);
        rd_chk("R10 write lands", 4'h0, 8'h40);

        // R11 hour decoded in 12-hour, read in 24-hour
        wr(4'hB, 8'h00);
        wr(4'h4, 8'h81);
        wr(4'hB, 8'h02);
        rd_chk("R11 1pm as 24h", 4'h4, 8'h13);

        // R3 long run: 3700 s from midnight
        wr(4'h4, 8'h00); wr(4'h2, 8'h00); wr(4'h0, 8'h00);
        for (int k = 0; k < 3700; k++) tick();
        rd_chk("R3 long hour", 4'h4, 8'h01);
        rd_chk("R3 long min",  4'h2, 8'h01);
        rd_chk("R3 long sec",  4'h0, 8'h40);

        finish_run();
    end
endmodule